// File: doc/BRIEF.md
# Peripheral Buffer Transfer Channel

This block moves data items between a peripheral's data register and a buffer in memory, one item per request, with no processor involvement per item. Software loads a buffer address and an item count through a small write-strobe register port, then enables or disables the end-of-buffer interrupt. The peripheral's ready flag paces the transfers: data-present for a receiver, room-available for a transmitter.

Each accepted transfer raises a single memory request and holds it until the acknowledge arrives. On the acknowledge, the count drops by one and the address moves to the next item. The channel then pulses a strobe toward the peripheral, either to pop the received item or to load the fetched one. When the count runs out, a sticky end flag rises and the channel stays quiet until a new nonzero count is written.

The same module serves both directions. A parameter selects the receive variant, which writes memory, or the transmit variant, which reads it.

Top module: `pbx_channel`

## Requirements
- R1: After reset, `ptr_o` and `cnt_o` are zero, `end_o` is 1, and `irq_o`, `mem_req` and `periph_strobe` are 0.
- R2: A write with `reg_sel`=0 loads the address pointer and `reg_sel`=1 loads the count. The new value appears on `ptr_o` or `cnt_o` in the cycle after the write.
- R3: When the count is nonzero, `ready` is high and the channel is armed, `mem_req` rises in the next cycle with `mem_addr` equal to the pointer. In the receive variant, `mem_we` is 1 and `mem_wdata` holds the `periph_rdata` sampled when the request was issued.
- R4: `mem_req` and `mem_addr` hold steady until `mem_ack` is seen. Each acknowledge lowers the count by one and advances the pointer by DATA_W/8 bytes (1 for 8-bit data).
- R5: The cycle after an acknowledge, `periph_strobe` is high for exactly one cycle and `mem_req` is low.
- R6: Only one request is outstanding at a time. After a transfer, no new request is made until `ready` has been seen low and then high again.
- R7: When the count reaches zero, `end_o` is set. While the count stays zero, no request is issued, whatever `ready` does.
- R8: Writing a nonzero count clears `end_o` and re-arms the channel. Writing a zero count sets `end_o`.
- R9: `irq_o` is high only when `end_o` is high and the interrupt mask bit is set. A write with `reg_sel`=2 sets the mask bit, a write with `reg_sel`=3 clears it, and the mask bit is clear after reset.
- R10: In the transmit variant (IS_TX=1), `mem_we` is 0. The `mem_rdata` captured on the acknowledge is presented on `periph_wdata` while `periph_strobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pointer, 1 count, 2 mask set, 3 mask clear |
| reg_wdata | input | REG_W | Register write data |
| ptr_o | output | ADDR_W | Current buffer address |
| cnt_o | output | CNT_W | Items remaining |
| end_o | output | 1 | Sticky end-of-buffer flag |
| irq_o | output | 1 | Masked interrupt request |
| ready | input | 1 | Peripheral ready flag (data present, or room available) |
| periph_rdata | input | DATA_W | Data from the peripheral (receive variant) |
| periph_wdata | output | DATA_W | Data to the peripheral (transmit variant) |
| periph_strobe | output | 1 | One-cycle pop or load pulse to the peripheral |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a memory write, 0 for a memory read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
A count register that has drifted from the true number of items shows up within one acknowledge. `cnt_o` steps by the wrong amount, or `end_o` rises too early or too late, so the total number of requests differs from the number of items offered. A broken arming latch shows as a second request while `ready` is still high after a strobe, one cycle after that strobe. A wrong pointer shows as an unexpected address at the very next request.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_IEN  = 2'd2,
        SEL_IDIS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic issue;   // a request is launched at this edge
        logic done;    // the outstanding request is acknowledged at this edge
    } seq_evt_t;

    function automatic int unsigned step_bytes(input int unsigned data_bits);
        return (data_bits + 7) / 8;
    endfunction

endpackage

// File: rtl/pbx_regs.sv
module pbx_regs
    import pbx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  reg_sel_e          reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  seq_evt_t          evt,
    output logic [ADDR_W-1:0] ptr,
    output logic [CNT_W-1:0]  cnt,
    output logic              end_flag,
    output logic              irq_en
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(step_bytes(DATA_W));
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

    logic cnt_nz;
    assign cnt_nz = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            cnt      <= '0;
            end_flag <= 1'b1;
            irq_en   <= 1'b0;
        end else begin
            // transfer update; register writes below take precedence
            if (evt.done && cnt_nz) begin
                ptr <= ptr + STEP;
                cnt <= cnt - ONE;
                if (cnt == ONE) end_flag <= 1'b1;
            end
            if (reg_wr) begin
                unique case (reg_sel)
                    SEL_PTR: ptr <= reg_wdata[ADDR_W-1:0];
                    SEL_CNT: begin
                        cnt      <= reg_wdata[CNT_W-1:0];
                        end_flag <= (reg_wdata[CNT_W-1:0] == '0);
                    end
                    SEL_IEN:  irq_en <= 1'b1;
                    SEL_IDIS: irq_en <= 1'b0;
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pbx_seq.sv
module pbx_seq
    import pbx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cnt_nz,
    input  logic     ready,
    input  logic     ack,
    output seq_evt_t evt,
    output logic     req,
    output logic     strobe
);
    logic armed;

    always_comb begin
        evt.issue = !req && !strobe && cnt_nz && ready && armed;
        evt.done  = req && ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req    <= 1'b0;
            strobe <= 1'b0;
            armed  <= 1'b1;
        end else begin
            strobe <= 1'b0;
            if (!ready) armed <= 1'b1;
            if (evt.issue) begin
                req   <= 1'b1;
                armed <= 1'b0;
            end
            if (evt.done) begin
                req    <= 1'b0;
                strobe <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pbx_data.sv
module pbx_data
    import pbx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit IS_TX  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_evt_t          evt,
    input  logic [DATA_W-1:0] periph_rdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] periph_wdata
);
    logic [DATA_W-1:0] hold_q;

    generate
        if (IS_TX) begin : g_tx
            logic unused_rx;
            assign unused_rx = ^periph_rdata;
            always_ff @(posedge clk) begin
                if (rst)           hold_q <= '0;
                else if (evt.done) hold_q <= mem_rdata;
            end
            assign periph_wdata = hold_q;
            assign mem_wdata    = '0;
        end else begin : g_rx
            logic unused_tx;
            assign unused_tx = ^mem_rdata;
            always_ff @(posedge clk) begin
                if (rst)            hold_q <= '0;
                else if (evt.issue) hold_q <= periph_rdata;
            end
            assign mem_wdata    = hold_q;
            assign periph_wdata = '0;
        end
    endgenerate

endmodule

// File: rtl/pbx_channel.sv
module pbx_channel
    import pbx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int REG_W  = 32,
    parameter bit IS_TX  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              end_o,
    output logic              irq_o,
    input  logic              ready,
    input  logic [DATA_W-1:0] periph_rdata,
    output logic [DATA_W-1:0] periph_wdata,
    output logic              periph_strobe,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    seq_evt_t evt;
    logic     irq_en;
    logic     end_flag;

    pbx_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .REG_W(REG_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel_e'(reg_sel)),
        .reg_wdata (reg_wdata),
        .evt       (evt),
        .ptr       (ptr_o),
        .cnt       (cnt_o),
        .end_flag  (end_flag),
        .irq_en    (irq_en)
    );

    pbx_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .cnt_nz (cnt_o != '0),
        .ready  (ready),
        .ack    (mem_ack),
        .evt    (evt),
        .req    (mem_req),
        .strobe (periph_strobe)
    );

    pbx_data #(.DATA_W(DATA_W), .IS_TX(IS_TX)) u_data (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .periph_rdata (periph_rdata),
        .mem_rdata    (mem_rdata),
        .mem_wdata    (mem_wdata),
        .periph_wdata (periph_wdata)
    );

    assign mem_addr = ptr_o;
    assign mem_we   = !IS_TX;
    assign end_o    = end_flag;
    assign irq_o    = end_flag & irq_en;

endmodule

// File: rtl/pbx_checker.sv
module pbx_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [ADDR_W-1:0] ptr_o,
    input logic [CNT_W-1:0]  cnt_o,
    input logic              end_o,
    input logic              irq_o,
    input logic              periph_strobe,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !reg_wr && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1));

    a_r5_strobe_after_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (periph_strobe && !mem_req));

    a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
        periph_strobe |=> !periph_strobe);

    a_r7_idle_at_zero: assert property (@(posedge clk) disable iff (rst)
        (cnt_o == '0 && !mem_req) |=> !mem_req);

    a_r8_end_matches: assert property (@(posedge clk) disable iff (rst)
        end_o == (cnt_o == '0));

    a_r9_irq_needs_end: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> end_o);

    a_r9_mask_clear: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd3) |=> !irq_o);

endmodule

bind pbx_channel pbx_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_sel       (reg_sel),
    .ptr_o         (ptr_o),
    .cnt_o         (cnt_o),
    .end_o         (end_o),
    .irq_o         (irq_o),
    .periph_strobe (periph_strobe),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_ack       (mem_ack)
);

// File: tb/sim_pbx_channel.sv
`timescale 1ns/1ps
module sim_pbx_channel;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    // receive instance signals
    logic        reg_wr = 0;
    logic [1:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] ptr_o;
    logic [15:0] cnt_o;
    logic        end_o, irq_o, ready = 0, periph_strobe, mem_req, mem_we, mem_ack = 0;
    logic [7:0]  periph_rdata = 0, periph_wdata, mem_wdata, mem_rdata = 0;
    logic [31:0] mem_addr;

    // transmit instance signals
    logic        t_wr = 0;
    logic [1:0]  t_sel = 0;
    logic [31:0] t_wdata = 0;
    logic [31:0] t_ptr, t_addr;
    logic [15:0] t_cnt;
    logic        t_end, t_irq, t_ready = 0, t_strobe, t_req, t_we, t_ack = 0;
    logic [7:0]  t_pwdata, t_mwdata, t_mrdata = 0;

    pbx_channel u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ptr_o(ptr_o), .cnt_o(cnt_o), .end_o(end_o), .irq_o(irq_o), .ready(ready),
        .periph_rdata(periph_rdata), .periph_wdata(periph_wdata), .periph_strobe(periph_strobe),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    pbx_channel #(.IS_TX(1'b1)) u1 (
        .clk(clk), .rst(rst), .reg_wr(t_wr), .reg_sel(t_sel), .reg_wdata(t_wdata),
        .ptr_o(t_ptr), .cnt_o(t_cnt), .end_o(t_end), .irq_o(t_irq), .ready(t_ready),
        .periph_rdata(8'h00), .periph_wdata(t_pwdata), .periph_strobe(t_strobe),
        .mem_req(t_req), .mem_we(t_we), .mem_addr(t_addr), .mem_wdata(t_mwdata),
        .mem_rdata(t_mrdata), .mem_ack(t_ack)
    );

    int vectors = 0;
    int fails   = 0;
    int req_count = 0;
    logic [39:0] exp_q[$];   // {address, data}
    logic [31:0] exp_ptr;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic t_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        t_wr = 1; t_sel = sel; t_wdata = val;
        @(negedge clk);
        t_wr = 0;
    endtask

    // receive driver: offer one item, push the expected memory write, wait for the pop
    task automatic rx_put(input logic [7:0] d);
        @(negedge clk);
        periph_rdata = d;
        ready = 1;
        exp_q.push_back({exp_ptr, d});
        exp_ptr = exp_ptr + 1;
        while (!periph_strobe) @(negedge clk);
        check("R5 strobe high after ack", {31'd0, periph_strobe}, 32'd1);
        check("R5 req low with strobe", {31'd0, mem_req}, 32'd0);
        ready = 0;
        @(negedge clk);
        check("R5 strobe lasts one cycle", {31'd0, periph_strobe}, 32'd0);
    endtask

    // monitor: counts requests, answers them and compares with the scoreboard
    initial begin : monitor
        int delay = 0;
        logic prev = 0;
        forever begin
            @(negedge clk);
            if (mem_req && !prev) req_count++;
            prev = mem_req;
            if (mem_req && !mem_ack) begin
                repeat (delay) begin
                    @(negedge clk);
                    check("R4 req held", {31'd0, mem_req}, 32'd1);
                end
                if (exp_q.size() == 0) begin
                    check("R6 unexpected request", 32'd1, 32'd0);
                end else begin
                    logic [39:0] e;
                    e = exp_q.pop_front();
                    check("R3 address", mem_addr, e[39:8]);
                    check("R3 write data", {24'd0, mem_wdata}, {24'd0, e[7:0]});
                    check("R3 write enable", {31'd0, mem_we}, 32'd1);
                end
                mem_ack = 1;
                @(negedge clk);
                mem_ack = 0;
                prev = mem_req;
                delay = (delay + 1) % 3;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 ptr", ptr_o, 32'd0);
        check("R1 cnt", {16'd0, cnt_o}, 32'd0);
        check("R1 end", {31'd0, end_o}, 32'd1);
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        check("R1 req", {31'd0, mem_req}, 32'd0);
        check("R1 strobe", {31'd0, periph_strobe}, 32'd0);

        // R7: ready with zero count makes no request
        ready = 1;
        repeat (5) @(negedge clk);
        ready = 0;
        check("R7 no request at zero count", req_count, 32'd0);

        // R2 / R8 load registers
        wr(2'd0, 32'h0000_1000);
        check("R2 pointer load", ptr_o, 32'h0000_1000);
        wr(2'd1, 32'd3);
        check("R2 count load", {16'd0, cnt_o}, 32'd3);
        check("R8 nonzero count clears end", {31'd0, end_o}, 32'd0);
        wr(2'd2, 32'd0);
        check("R9 mask set, end low", {31'd0, irq_o}, 32'd0);

        // R3/R4: three transfers
        exp_ptr = 32'h0000_1000;
        rx_put(8'hA5);
        check("R4 count after first", {16'd0, cnt_o}, 32'd2);
        check("R4 pointer after first", ptr_o, 32'h0000_1001);
        rx_put(8'h3C);
        rx_put(8'hF0);
        check("R4 pointer after third", ptr_o, 32'h0000_1003);
        check("R7 count exhausted", {16'd0, cnt_o}, 32'd0);
        check("R7 end set", {31'd0, end_o}, 32'd1);
        check("R9 irq with mask", {31'd0, irq_o}, 32'd1);
        check("R3 request count", req_count, 32'd3);

        // R7: ready again while zero
        ready = 1;
        repeat (6) @(negedge clk);
        ready = 0;
        check("R7 quiet at zero", req_count, 32'd3);
        check("R7 count stays zero", {16'd0, cnt_o}, 32'd0);

        wr(2'd3, 32'd0);
        check("R9 mask cleared", {31'd0, irq_o}, 32'd0);
        check("R9 end still high", {31'd0, end_o}, 32'd1);

        // R6: ready held high after a transfer must not start another
        wr(2'd1, 32'd2);
        @(negedge clk);
        periph_rdata = 8'h11;
        ready = 1;
        exp_q.push_back({exp_ptr, 8'h11});
        exp_ptr = exp_ptr + 1;
        while (!periph_strobe) @(negedge clk);
        repeat (6) @(negedge clk);
        check("R6 single request while ready stays high", req_count, 32'd4);
        check("R6 count after one", {16'd0, cnt_o}, 32'd1);
        ready = 0;
        @(negedge clk);
        rx_put(8'h22);
        check("R6 second request after re-ready", req_count, 32'd5);
        check("R6 pointer", ptr_o, 32'h0000_1005);
        check("R7 end after second", {31'd0, end_o}, 32'd1);

        // R8: writing zero sets end
        wr(2'd1, 32'd4);
        check("R8 end cleared", {31'd0, end_o}, 32'd0);
        wr(2'd1, 32'd0);
        check("R8 zero write sets end", {31'd0, end_o}, 32'd1);
        check("R8 no request", req_count, 32'd5);
        check("R3 scoreboard drained", exp_q.size(), 32'd0);

        // R10: transmit variant
        t_write(2'd0, 32'h0000_0200);
        t_write(2'd1, 32'd1);
        @(negedge clk);
        t_ready = 1;
        begin
            int n = 0;
            while (!t_req && n < 20) begin @(negedge clk); n++; end
        end
        check("R10 tx request", {31'd0, t_req}, 32'd1);
        check("R10 tx address", t_addr, 32'h0000_0200);
        check("R10 tx read", {31'd0, t_we}, 32'd0);
        t_mrdata = 8'h5A;
        t_ack = 1;
        @(negedge clk);
        t_ack = 0;
        t_mrdata = 8'h00;
        check("R10 tx strobe", {31'd0, t_strobe}, 32'd1);
        check("R10 tx data to peripheral", {24'd0, t_pwdata}, 32'h5A);
        t_ready = 0;
        @(negedge clk);
        check("R10 tx end", {31'd0, t_end}, 32'd1);
        check("R10 tx pointer", t_ptr, 32'h0000_0201);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule